// File: doc/BRIEF.md
# Token Burst Sequencer

This block replays a stored run of ready-made tokens onto a token network. One trigger supplies a base address and a token count. The trigger is a single request with one operand, so it needs no operand matching. The block then reads the tokens from consecutive cells of a one-cycle-latency structure memory. Each token occupies two cells: the cell at `base + 2i` holds the first flit (command or tag), and the cell at `base + 2i + 1` holds the second flit (return routing or data).

Flits leave on a 16-bit valid/ready stream. Back-pressure rules on that stream:
- A flit is transferred only on a clock edge where `flit_valid` and `flit_ready` are both high.
- While `flit_valid` is high and `flit_ready` is low, the flit and its `flit_last` marker stay unchanged.
- The two flits of one token always follow each other with no idle cycle between them, so no other source can slip in between.

Reads are issued ahead into a small prefetch store, and only when room for a whole token is reserved. This keeps the flit order intact across stalls. A one-cycle done pulse ends every burst. While a burst runs, new triggers are refused.

Top module: `tbs_burst_seq`

## Requirements
- R1: After reset, `trig_ready` is 1, and `flit_valid`, `burst_done` and `mem_rd_en` are 0.
- R2: A trigger is taken on an edge where `trig_valid` and `trig_ready` are both high. `trig_ready` is low from the edge that takes a non-zero-count trigger until the final flit has been handed over. A trigger offered while `trig_ready` is low has no effect.
- R3: Token i of a burst is emitted as the cell at `base+2i` (first flit, `flit_last`=0) followed by the cell at `base+2i+1` (second flit, `flit_last`=1), in ascending token order.
- R4: A burst with count N emits exactly 2N flits, and no flit is presented after the burst ends.
- R5: While `flit_valid` is high and `flit_ready` is low, the next cycle still has `flit_valid` high with `flit_data` and `flit_last` unchanged; no flit is lost or repeated.
- R6: On the cycle after a first flit is transferred, the matching second flit is presented (`flit_valid`=1, `flit_last`=1).
- R7: `burst_done` is high for exactly one cycle, namely the cycle after the edge that transfers the burst's final second flit.
- R8: A trigger with count 0 raises `burst_done` on the cycle after it is taken, issues no memory read and emits no flit.
- R9: Cell addresses increase modulo 2^ADDR_W, so a burst that runs past the top cell continues at cell 0.
- R10: With `flit_ready` held high, the first flit of a burst is presented two clock edges after the edge that takes the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | High when a trigger can be taken (no burst active) |
| trig_base | input | ADDR_W | Cell address of the first flit of the burst |
| trig_count | input | CNT_W | Number of two-flit tokens in the burst |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 16 | Read data, valid the cycle after `mem_rd_en` |
| flit_valid | output | 1 | Output flit valid |
| flit_ready | input | 1 | Downstream can take the flit |
| flit_data | output | 16 | Output flit |
| flit_last | output | 1 | Marks the second flit of a token |
| burst_done | output | 1 | One-cycle pulse when a burst completes |

## Verification
The first flit of a burst is due two edges after the accepting edge: one edge for the read, one for the prefetch write. Each later flit is due on the cycle after the previous transfer, unless the stall pattern or a refill gap delays it. `burst_done` is due exactly one edge after the last transfer, or one edge after a zero-count trigger. The bench drives inputs and samples outputs at the falling edge. At each falling edge it records a flit only when valid and its own ready are both high, because that transfer completes on the next rising edge. It expects done at the very next falling edge. Timing-sensitive checks, namely first-flit latency and done placement, are counted in falling-edge iterations from the trigger.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int FLIT_W = 16;

  typedef logic [FLIT_W-1:0] flit_t;

  // one prefetch slot: the flit plus whether it is the second of its token
  typedef struct packed {
    logic  second;
    flit_t data;
  } slot_t;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/tbs_addr_gen.sv
// Issues cell reads two at a time (first flit, then second flit on the
// very next cycle); a pair starts only when the prefetch store has room
// reserved for both.
module tbs_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              room_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_second_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              phase_q;
  logic              issue;

  assign issue       = phase_q || ((left_q != '0) && room_i);
  assign rd_en_o     = issue;
  assign rd_addr_o   = addr_q;
  assign rd_second_o = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      phase_q <= 1'b0;
    end else if (start_i) begin
      addr_q  <= base_i;
      left_q  <= count_i;
      phase_q <= 1'b0;
    end else if (issue) begin
      addr_q  <= addr_q + ADDR_W'(1);
      phase_q <= ~phase_q;
      if (phase_q) left_q <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tbs_flit_fifo.sv
// Prefetch store. Occupancy counts both stored slots and reads in flight,
// so a reserved read always finds a free slot when its data returns.
module tbs_flit_fifo
  import tbs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reserve_i,
  input  logic  push_i,
  input  slot_t push_slot_i,
  input  logic  pop_i,
  output logic  avail_o,
  output slot_t head_o,
  output logic  room_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  slot_t          store_q [DEPTH];
  logic [PW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  cnt_q, occ_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign avail_o = (cnt_q != '0);
  assign head_o  = store_q[rd_ptr_q];
  assign room_o  = (occ_q <= CW'(DEPTH - 2));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && (wr_ptr_q == PW'(g))) store_q[g] <= push_slot_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      occ_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_next(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
      occ_q <= occ_q + CW'(reserve_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/tbs_burst_ctl.sv
// Burst bookkeeping: accepts triggers, counts completed tokens, pulses done.
module tbs_burst_ctl
  import tbs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_valid_i,
  input  logic [CNT_W-1:0] trig_count_i,
  input  logic             pop_last_i,
  output logic             trig_ready_o,
  output logic             start_o,
  output logic             done_o
);
  ctl_state_e       st_q;
  logic [CNT_W-1:0] left_q;
  logic             done_q;
  logic             fire;

  assign trig_ready_o = (st_q == CTL_IDLE);
  assign fire         = trig_valid_i && trig_ready_o;
  assign start_o      = fire && (trig_count_i != '0);
  assign done_o       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CTL_IDLE;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        if (trig_count_i == '0) begin
          done_q <= 1'b1;
        end else begin
          st_q   <= CTL_RUN;
          left_q <= trig_count_i;
        end
      end else if ((st_q == CTL_RUN) && pop_last_i) begin
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          st_q   <= CTL_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tbs_burst_seq.sv
module tbs_burst_seq
  import tbs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [ADDR_W-1:0] trig_base,
  input  logic [CNT_W-1:0]  trig_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [FLIT_W-1:0] mem_rd_data,
  output logic              flit_valid,
  input  logic              flit_ready,
  output logic [FLIT_W-1:0] flit_data,
  output logic              flit_last,
  output logic              burst_done
);
  logic  start, room, rd_en, rd_second;
  logic  rd_pend_q, rd_second_q;
  logic  avail, pop, pop_last;
  slot_t head, push_slot;

  tbs_burst_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid_i (trig_valid),
    .trig_count_i (trig_count),
    .pop_last_i   (pop_last),
    .trig_ready_o (trig_ready),
    .start_o      (start),
    .done_o       (burst_done)
  );

  tbs_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) agen_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .base_i      (trig_base),
    .count_i     (trig_count),
    .room_i      (room),
    .rd_en_o     (rd_en),
    .rd_addr_o   (mem_rd_addr),
    .rd_second_o (rd_second)
  );

  assign mem_rd_en = rd_en;

  // align the slot marker with the data the memory returns one cycle later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q   <= 1'b0;
      rd_second_q <= 1'b0;
    end else begin
      rd_pend_q   <= rd_en;
      rd_second_q <= rd_second;
    end
  end

  assign push_slot = '{second: rd_second_q, data: mem_rd_data};

  tbs_flit_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reserve_i   (rd_en),
    .push_i      (rd_pend_q),
    .push_slot_i (push_slot),
    .pop_i       (pop),
    .avail_o     (avail),
    .head_o      (head),
    .room_o      (room)
  );

  assign flit_valid = avail;
  assign flit_data  = head.data;
  assign flit_last  = head.second;
  assign pop        = avail && flit_ready;
  assign pop_last   = pop && head.second;
endmodule

// File: rtl/tbs_burst_seq_chk.sv
module tbs_burst_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_valid,
  input logic             trig_ready,
  input logic [CNT_W-1:0] trig_count,
  input logic             mem_rd_en,
  input logic             flit_valid,
  input logic             flit_ready,
  input logic [15:0]      flit_data,
  input logic             flit_last,
  input logic             burst_done
);
  // R5: a stalled flit stays presented and unchanged
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data) && $stable(flit_last)));

  // R6: second flit follows the first with no gap
  a_r6_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && flit_ready && !flit_last) |=> (flit_valid && flit_last));

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R7 / R8: done only after a final transfer or an empty trigger
  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> ($past(flit_valid && flit_ready && flit_last) ||
                    $past(trig_valid && trig_ready && (trig_count == '0))));

  // R8: an empty trigger completes on the next cycle
  a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready && (trig_count == '0)) |=> burst_done);

  // R8 / R2: reads happen only inside an active burst
  a_r8_read_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !trig_ready);

  // R2: a non-empty trigger makes the block busy
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready && (trig_count != '0)) |=> !trig_ready);
endmodule

bind tbs_burst_seq tbs_burst_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_valid (trig_valid),
  .trig_ready (trig_ready),
  .trig_count (trig_count),
  .mem_rd_en  (mem_rd_en),
  .flit_valid (flit_valid),
  .flit_ready (flit_ready),
  .flit_data  (flit_data),
  .flit_last  (flit_last),
  .burst_done (burst_done)
);

// File: tb/tbs_burst_seq_tb_top.sv
`timescale 1ns/1ps
module tbs_burst_seq_tb_top;
  localparam int CLK_NS = 20;  // 50 MHz
  localparam int NVEC   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [7:0]  trig_base = '0;
  logic [7:0]  trig_count = '0;
  logic        mem_rd_en;
  logic [7:0]  mem_rd_addr;
  logic [15:0] mem_rd_data;
  logic        flit_valid;
  logic        flit_ready = 1'b0;
  logic [15:0] flit_data;
  logic        flit_last;
  logic        burst_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'h5B;

  always #(CLK_NS/2) clk = ~clk;

  tbs_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_base(trig_base), .trig_count(trig_count),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data), .flit_last(flit_last),
    .burst_done(burst_done)
  );

  function automatic logic [15:0] cell_val(input logic [7:0] a);
    return {a, ~a} ^ 16'h3C5A;
  endfunction

  // memory model: one-cycle read latency
  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= cell_val(mem_rd_addr);
  end

  // vector: {base[7:0], count[7:0], ready mode[1:0], refused-trigger flag}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'h10, 8'd1,  2'd0, 1'b0},
    {8'h20, 8'd4,  2'd0, 1'b1},
    {8'h40, 8'd5,  2'd1, 1'b0},
    {8'h03, 8'd3,  2'd2, 1'b0},
    {8'hFC, 8'd3,  2'd3, 1'b0},
    {8'h80, 8'd20, 2'd3, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ready_for(input logic [1:0] mode, input int it, input logic [7:0] rnd);
    case (mode)
      2'd0: return 1'b1;
      2'd1: return it[0];
      2'd2: return (it % 3) == 0;
      default: return rnd[0] ^ rnd[3];
    endcase
  endfunction

  task automatic run_burst(input logic [7:0] base, input logic [7:0] cnt,
                           input logic [1:0] mode, input bit inj);
    int  k = 0;
    bit  last_seen = 0;
    bit  got_done = 0;
    bit  r;
    logic [7:0] a;
    @(negedge clk);
    check(trig_ready == 1'b1, "R2 ready before trigger", int'(trig_ready), 1);
    trig_base = base; trig_count = cnt; trig_valid = 1'b1;
    for (int it = 0; it < 3000 && !got_done; it++) begin
      @(negedge clk);
      if (it == 0) trig_valid = 1'b0;
      if (inj && it == 3) begin
        trig_base = 8'h00; trig_count = 8'd7; trig_valid = 1'b1;
        check(trig_ready == 1'b0, "R2 busy refuses trigger", int'(trig_ready), 0);
      end
      if (inj && it == 4) trig_valid = 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (last_seen) begin
        check(burst_done == 1'b1, "R7 done after final flit", int'(burst_done), 1);
        got_done = 1;
      end else if (burst_done) begin
        check(1'b0, "R7 done before final flit", k, 2 * int'(cnt));
        got_done = 1;
      end else begin
        r = ready_for(mode, it, lfsr);
        flit_ready = r;
        if (flit_valid && r) begin
          if (k == 0 && mode == 2'd0)
            check(it == 2, "R10 first flit latency", it, 2);
          a = base + 8'(k);
          check(flit_data == cell_val(a), "R3 R9 flit data", int'(flit_data), int'(cell_val(a)));
          check(flit_last == k[0], "R3 flit_last marker", int'(flit_last), k & 1);
          k++;
          if (k == 2 * int'(cnt)) last_seen = 1;
        end
      end
    end
    if (!got_done) check(1'b0, "R4 burst timed out", k, 2 * int'(cnt));
    flit_ready = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(flit_valid == 1'b0, "R4 no extra flit", int'(flit_valid), 0);
      check(burst_done == 1'b0, "R7 done single cycle", int'(burst_done), 0);
      check(trig_ready == 1'b1, "R2 ready after burst", int'(trig_ready), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(trig_ready == 1'b1, "R1 trig_ready", int'(trig_ready), 1);
    check(flit_valid == 1'b0, "R1 flit_valid", int'(flit_valid), 0);
    check(burst_done == 1'b0, "R1 burst_done", int'(burst_done), 0);
    check(mem_rd_en == 1'b0, "R1 mem_rd_en", int'(mem_rd_en), 0);

    for (int v = 0; v < NVEC; v++)
      run_burst(VEC[v][18:11], VEC[v][10:3], VEC[v][2:1], VEC[v][0]);

    // R8: empty burst
    @(negedge clk);
    trig_base = 8'h55; trig_count = 8'd0; trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    check(burst_done == 1'b1, "R8 empty done", int'(burst_done), 1);
    check(flit_valid == 1'b0, "R8 empty no flit", int'(flit_valid), 0);
    check(mem_rd_en == 1'b0, "R8 empty no read", int'(mem_rd_en), 0);
    @(negedge clk);
    check(burst_done == 1'b0, "R8 empty done one cycle", int'(burst_done), 0);
    check(flit_valid == 1'b0, "R8 empty still no flit", int'(flit_valid), 0);

    // R9: wrap from the top cell with full stall first (R5)
    flit_ready = 1'b0;
    run_burst(8'hFF, 8'd2, 2'd2, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule